// File: doc/BRIEF.md
# Two-Bit Branch History Predictor

This block guesses the direction of conditional branches for an instruction fetch stage. A direct-mapped table of small saturating counters sits behind it, and low bits of the program counter select the entry. On each cycle the fetch stage presents a PC on the lookup port, and the block returns a taken or not-taken guess in that same cycle, with no register in the path. Once a branch resolves, the execute stage sends the branch PC and its real outcome to the update port. On the next clock edge the selected entry moves one step.

Each entry is a four-state machine. The states are `BH_SNT` (strongly not taken), `BH_WNT` (weakly not taken), `BH_WT` (weakly taken) and `BH_ST` (strongly taken). A taken outcome moves the entry one step towards `BH_ST`: SNT→WNT, WNT→WT, WT→ST, and ST→ST saturates. A not-taken outcome moves it one step towards `BH_SNT`: ST→WT, WT→WNT, WNT→SNT, and SNT→SNT saturates. With no update, the state holds. Because the direction only flips after two wrong outcomes in a row, a loop that exits once per pass costs one misprediction per pass.

A mode input selects a static guess instead of the table. In static mode a backward branch (negative displacement) is predicted taken and a forward branch is predicted not taken. A hint bit from the instruction inverts that guess. The table keeps training while static mode is selected.

Top module: `bhp_predictor`

## Requirements
- R1: After reset every entry is in `BH_WNT`, so a dynamic-mode lookup of any PC predicts not taken (lk_taken = 0).
- R2: The entry index is PC bits [7:2] (64 entries). Two PCs that differ only in bits [1:0] or in bits above 7 share one entry. An update changes exactly one entry.
- R3: In dynamic mode lk_taken is 1 when the looked-up entry is in `BH_WT` or `BH_ST`, and 0 when it is in `BH_SNT` or `BH_WNT`.
- R4: An update with upd_taken = 1 moves the entry one step towards `BH_ST` and saturates there. An update with upd_taken = 0 moves it one step towards `BH_SNT` and saturates there.
- R5: A single opposite outcome applied to an entry in a strong state leaves the predicted direction unchanged. A second consecutive opposite outcome flips it.
- R6: When upd_valid = 0 no entry changes, whatever upd_pc and upd_taken carry.
- R7: An update takes effect on the clock edge that samples it. A lookup of the same entry in the same cycle returns the prediction from before that update.
- R8: With use_static = 1, lk_taken = (sign bit of lk_disp) XOR lk_hint, independent of the table contents.
- R9: Updates applied while use_static = 1 still train the table, and this is visible after returning to dynamic mode.
- R10: Replaying a loop branch with the outcome pattern taken, taken, taken, not taken gives exactly one misprediction per pass once the entry has warmed up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| use_static | input | 1 | 1 selects the static displacement/hint guess, 0 the history table |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_disp | input | 13 | Signed branch displacement of the fetched branch |
| lk_hint | input | 1 | Instruction hint bit; inverts the static guess |
| lk_taken | output | 1 | Prediction for lk_pc, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented on the update port |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
A lookup and an update can fall in the same cycle on the same entry. Both are also live in the same cycle while static mode is selected. The bench drives a lookup and a state-changing update to one PC in one cycle, samples lk_taken before the clock edge and expects the old direction, then samples again after the edge and expects the new one. Separately, it trains an entry while static mode is on and checks that the static guess never moves. After switching back to dynamic mode it confirms that the training took hold.

// File: rtl/bhp_pkg.sv
package bhp_pkg;
    // Two-bit history state; bit 1 is the predicted direction.
    typedef enum logic [1:0] {
        BH_SNT = 2'b00,
        BH_WNT = 2'b01,
        BH_WT  = 2'b10,
        BH_ST  = 2'b11
    } bh_state_e;
endpackage

// File: rtl/bhp_index_dec.sv
module bhp_index_dec #(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 6,
    parameter int IDX_LSB = 2,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic [PC_W-1:0]    pc,
    input  logic               en,
    output logic [IDX_W-1:0]   idx,
    output logic [ENTRIES-1:0] sel
);
    assign idx = pc[IDX_LSB +: IDX_W];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_sel
        assign sel[g] = en && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/bhp_cell.sv
module bhp_cell
    import bhp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_en,
    input  logic       upd_taken,
    output logic       pred,
    output logic [1:0] st_o
);
    bh_state_e cur, nxt;

    // Next-state logic: one saturating step per update.
    always_comb begin
        nxt = cur;
        if (upd_en) begin
            unique case (cur)
                BH_SNT: nxt = upd_taken ? BH_WNT : BH_SNT;
                BH_WNT: nxt = upd_taken ? BH_WT  : BH_SNT;
                BH_WT:  nxt = upd_taken ? BH_ST  : BH_WNT;
                BH_ST:  nxt = upd_taken ? BH_ST  : BH_WT;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= BH_WNT;
        else        cur <= nxt;
    end

    // Outputs.
    always_comb begin
        unique case (cur)
            BH_SNT, BH_WNT: pred = 1'b0;
            BH_WT,  BH_ST:  pred = 1'b1;
        endcase
        st_o = cur;
    end
endmodule

// File: rtl/bhp_static.sv
module bhp_static #(
    parameter int DISP_W = 13
) (
    input  logic [DISP_W-1:0] disp,
    input  logic              hint,
    output logic              pred
);
    logic backward;
    assign backward = disp[DISP_W-1];
    assign pred     = backward ^ hint;
endmodule

// File: rtl/bhp_predictor.sv
module bhp_predictor #(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 6,
    parameter int IDX_LSB = 2,
    parameter int DISP_W  = 13,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              use_static,
    input  logic [PC_W-1:0]   lk_pc,
    input  logic [DISP_W-1:0] lk_disp,
    input  logic              lk_hint,
    output logic              lk_taken,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic              upd_taken
);
    logic [IDX_W-1:0]     lk_idx;
    logic [IDX_W-1:0]     upd_idx;
    logic [ENTRIES-1:0]   upd_sel;
    logic [ENTRIES-1:0]   pred_vec;
    logic [2*ENTRIES-1:0] st_flat;
    logic                 dyn_pred;
    logic                 stat_pred;

    assign lk_idx = lk_pc[IDX_LSB +: IDX_W];

    bhp_index_dec #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_upd_dec (
        .pc  (upd_pc),
        .en  (upd_valid),
        .idx (upd_idx),
        .sel (upd_sel)
    );

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        bhp_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .upd_en    (upd_sel[e]),
            .upd_taken (upd_taken),
            .pred      (pred_vec[e]),
            .st_o      (st_flat[2*e +: 2])
        );
    end

    assign dyn_pred = pred_vec[lk_idx];

    bhp_static #(.DISP_W(DISP_W)) u_static (
        .disp (lk_disp),
        .hint (lk_hint),
        .pred (stat_pred)
    );

    assign lk_taken = use_static ? stat_pred : dyn_pred;
endmodule

// File: rtl/bhp_checker.sv
module bhp_checker #(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 6,
    parameter int IDX_LSB = 2,
    parameter int DISP_W  = 13,
    localparam int ENTRIES = 1 << IDX_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 use_static,
    input logic [DISP_W-1:0]    lk_disp,
    input logic                 lk_hint,
    input logic                 lk_taken,
    input logic                 upd_valid,
    input logic [PC_W-1:0]      upd_pc,
    input logic                 upd_taken,
    input logic [ENTRIES-1:0]   upd_sel,
    input logic [2*ENTRIES-1:0] st_flat
);
    logic             pv_valid;
    logic             pv_taken;
    logic [IDX_W-1:0] pv_idx;
    logic [1:0]       pv_state;
    logic [1:0]       now_state;
    logic [1:0]       exp_state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pv_valid <= 1'b0;
            pv_taken <= 1'b0;
            pv_idx   <= '0;
            pv_state <= 2'b01;
        end else begin
            pv_valid <= upd_valid;
            pv_taken <= upd_taken;
            pv_idx   <= upd_pc[IDX_LSB +: IDX_W];
            pv_state <= st_flat[2*int'(upd_pc[IDX_LSB +: IDX_W]) +: 2];
        end
    end

    assign now_state = st_flat[2*int'(pv_idx) +: 2];

    // Arithmetic form of the saturating step.
    always_comb begin
        if (pv_taken) exp_state = (pv_state == 2'd3) ? 2'd3 : pv_state + 2'd1;
        else          exp_state = (pv_state == 2'd0) ? 2'd0 : pv_state - 2'd1;
    end

    a_r2_one_entry: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $countones(upd_sel) == 1);
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(st_flat));
    a_r4_sat_step: assert property (@(posedge clk) disable iff (!rst_n)
        pv_valid |-> now_state == exp_state);
    a_r5_strong_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_valid && (pv_state == 2'd0 || pv_state == 2'd3)) |-> now_state[1] == pv_state[1]);
    a_r8_static_rule: assert property (@(posedge clk) disable iff (!rst_n)
        use_static |-> lk_taken == (lk_disp[DISP_W-1] ^ lk_hint));
endmodule

bind bhp_predictor bhp_checker #(
    .PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB), .DISP_W(DISP_W)
) u_chk (.*);

// File: tb/tb_bhp_predictor.sv
module tb_bhp_predictor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        use_static = 1'b0;
    logic [31:0] lk_pc = '0;
    logic [12:0] lk_disp = '0;
    logic        lk_hint = 1'b0;
    logic        lk_taken;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;

    int nvec = 0;
    int nfail = 0;
    int mdl [64];
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    bhp_predictor dut (.*);

    function automatic int ix(input logic [31:0] pc);
        return int'(pc[7:2]);
    endfunction

    task automatic look(input logic [31:0] pc, input logic exp, input string tag);
        lk_pc = pc;
        #1;
        nvec++;
        if (lk_taken !== exp) begin
            nfail++;
            $display("FAIL %s pc=%h actual=%0b expected=%0b", tag, pc, lk_taken, exp);
        end
    endtask

    task automatic upd(input logic [31:0] pc, input logic t);
        @(negedge clk);
        upd_pc = pc; upd_taken = t; upd_valid = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0;
        if (t) mdl[ix(pc)] = (mdl[ix(pc)] == 3) ? 3 : mdl[ix(pc)] + 1;
        else   mdl[ix(pc)] = (mdl[ix(pc)] == 0) ? 0 : mdl[ix(pc)] - 1;
    endtask

    function automatic logic mp(input logic [31:0] pc);
        return mdl[ix(pc)] >= 2;
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) mdl[i] = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every entry weakly not taken
        for (int i = 0; i < 64; i++) look(32'(i) << 2, 1'b0, "R1 reset");

        // R3 R4 R2: pseudo-random training; aliased PCs (high bits, low bits vary)
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < 64; i++) begin
                logic [31:0] pc;
                pc = {22'(r * 977 + i), 6'(i), 2'(r)};
                look(pc, mp(pc), "R3/R2 lookup");
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                upd(pc, lfsr[0]);
            end
        end
        for (int i = 0; i < 64; i++) look({24'hFFFF00, 6'(i), 2'b11}, mdl[i] >= 2, "R4 after sweep");

        // R5: strong taken, one miss keeps direction, second flips
        upd(32'h14, 1'b1); upd(32'h14, 1'b1); upd(32'h14, 1'b1); upd(32'h14, 1'b1);
        look(32'h14, 1'b1, "R4 saturate taken");
        upd(32'h14, 1'b0);
        look(32'h14, 1'b1, "R5 single miss keeps");
        upd(32'h14, 1'b0);
        look(32'h14, 1'b0, "R5 second miss flips");
        upd(32'h14, 1'b0); upd(32'h14, 1'b0); upd(32'h14, 1'b0);
        upd(32'h14, 1'b1);
        look(32'h14, 1'b0, "R5 strong NT single miss keeps");

        // R6: idle update port with moving payload
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            upd_valid = 1'b0; upd_pc = 32'(k * 36); upd_taken = k[0];
        end
        @(negedge clk);
        for (int i = 0; i < 64; i++) look(32'(i) << 2, mdl[i] >= 2, "R6 idle hold");

        // R7: same-cycle lookup and update on one entry
        upd(32'h24, 1'b0); upd(32'h24, 1'b0); upd(32'h24, 1'b0); upd(32'h24, 1'b1);
        @(negedge clk);
        upd_pc = 32'h24; upd_taken = 1'b1; upd_valid = 1'b1;
        look(32'h24, 1'b0, "R7 pre-update value");
        @(negedge clk);
        upd_valid = 1'b0;
        mdl[9] = 2;
        look(32'h24, 1'b1, "R7 post-update value");

        // R8 R9: static mode sweep while training entry 20
        use_static = 1'b1;
        for (int d = 0; d < 16; d++) begin
            for (int h = 0; h < 2; h++) begin
                logic [12:0] dv;
                dv = (d < 8) ? 13'(d * 511) : 13'(-(d * 257 + 1));
                lk_disp = dv; lk_hint = h[0];
                look(32'(d) << 2, dv[12] ^ h[0], "R8 static");
            end
            upd(32'h50, 1'b1);
        end
        use_static = 1'b0;
        look(32'h50, 1'b1, "R9 trained in static mode");

        // R10: loop pattern T T T N
        upd(32'h1000_0040, 1'b0); upd(32'h1000_0040, 1'b0); upd(32'h1000_0040, 1'b0);
        for (int it = 0; it < 8; it++) begin
            int miss;
            miss = 0;
            for (int s = 0; s < 4; s++) begin
                logic o;
                o = (s != 3);
                look(32'h1000_0040, mp(32'h1000_0040), "R10 loop lookup");
                if (lk_taken != o) miss++;
                upd(32'h1000_0040, o);
            end
            if (it >= 1) begin
                nvec++;
                if (miss != 1) begin
                    nfail++;
                    $display("FAIL R10 pass %0d mispredicts actual=%0d expected=1", it, miss);
                end
            end
        end

        finish_run();
    end
endmodule